// File: doc/BRIEF.md
# Multichannel CPU Register Interface

This block is a synchronous slave between a host processor bus and a bank of receive and transmit channels. It splits a 9-bit address into a channel number, a direction bit, a register selector and a byte index. It reaches a 32-bit register image of the addressed channel through a host data bus that is 8, 16 or 32 bits wide. Every access is held off with a wait signal. The number of wait cycles depends on the kind of access: a fast path for the small control and status registers, a slow path for the data word and the label store, and a fixed two-cycle path for every write.

Each channel is modelled as a register stub. The stub has a 32-bit data word, an 8-bit control register and a read-only status byte. Receive channels also have a small label store, reached through auto-advancing read and write pointers. The interrupt of each channel is raised while its data word is nonzero. One global interrupt combines all of them. On a narrow bus, the parts of a data word are collected in a staging register and are passed to the channel as one word when the top part arrives.

Top module: `cpu_regif`

## Requirements
- R1: The address splits as bits 8:5 channel (0..15), bit 4 direction (0 receive, 1 transmit), bits 3:2 register (00 data word, 01 control, 10 status, 11 label store on receive and unused on transmit) and bits 1:0 byte index. Each channel and direction holds its own registers, with no aliasing between them.
- R2: If cpu_ren_n or cpu_wen_n is sampled low while the block is idle, cpu_wait is high from the next cycle until the access completes. After completion, cpu_wait stays low and no new access starts until both enables have been seen high. If both enables are low, the access is a read.
- R3: A read of control or status keeps cpu_wait high for exactly 1 cycle. A read of the data word or of the label slot keeps it high for exactly 6 cycles. cpu_rdata holds the result when cpu_wait falls and does not change until the next read completes.
- R4: Every write keeps cpu_wait high for exactly 2 cycles. The target register shows the new value when cpu_wait falls.
- R5: The bus lane is the byte index shifted right by log2(DW/8). The lane reaches register bits [lane*DW +: DW]. With an 8-bit bus, index 0 is bits 7:0 and index 3 is bits 31:24. With a 16-bit bus, 00 is the low half and 10 is the high half. A 32-bit bus uses lane 0 only.
- R6: A data-word write to a lane below the top one only loads a staging register that all channels share. The channel's word does not change. A write to the top lane passes {top part, staged parts} to the channel named in that final write.
- R7: Control is an 8-bit read/write field in lane 0 (bits 7:0). Other lanes read zero, and writes to them are ignored.
- R8: Status is read-only. Bit 0 is 1 when the channel's data word is zero, and the other bits are 0. Writes to status are ignored.
- R9: Each receive channel has an LBL_DEPTH-entry label store of 8 bits per entry. A lane-0 write stores at the write pointer. A lane-0 read returns the entry at the read pointer. Each pointer then advances and wraps at LBL_DEPTH. A control write with bit 7 = 1 returns both pointers to 0 but keeps the contents. Label accesses on other lanes read zero and move no pointer.
- R10: A channel number at or beyond NRX (receive) or NTX (transmit), and the transmit label slot, read as zero with the latency of R3. Writes to them change no register.
- R11: rx_irq[i] and tx_irq[i] are 1 while that channel's data word is nonzero. irq_out is the OR of all channel interrupts.
- R12: After reset, cpu_wait, cpu_rdata and irq_out are 0, and all channel registers, pointers and label entries are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_ren_n | input | 1 | Read enable, active low |
| cpu_wen_n | input | 1 | Write enable, active low |
| cpu_addr | input | 9 | Channel, direction, register and byte index |
| cpu_wdata | input | DW | Write data for the addressed lane |
| cpu_rdata | output | DW | Read data of the last completed read |
| cpu_wait | output | 1 | High while an access is in progress |
| rx_irq | output | NRX | Per receive channel interrupt |
| tx_irq | output | NTX | Per transmit channel interrupt |
| irq_out | output | 1 | OR of all channel interrupts |

## Verification
The completion edge of a write does two things at once: it drops cpu_wait, and it updates the target register. For the final lane of a data word, that same edge also commits the staged word and raises the channel interrupt. The bench provokes this by writing the top byte of a word, and by writing the lower bytes to one channel and the top byte to another. At the first sample after cpu_wait falls, it judges irq_out, the per-channel interrupt vectors and the status byte together. It then reads every lane back and compares each value with the word assembled from the bytes it wrote.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;

  typedef enum logic [1:0] {
    RG_DATA = 2'b00,
    RG_CTRL = 2'b01,
    RG_STAT = 2'b10,
    RG_LBL  = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic [3:0] ch;
    logic       is_tx;
    reg_sel_e   rsel;
    logic [1:0] bidx;
  } acc_t;

  localparam int RD_FAST = 1;
  localparam int RD_SLOW = 6;
  localparam int WR_LAT  = 2;

  function automatic acc_t decode_addr(input logic [8:0] a);
    acc_t r;
    r.ch    = a[8:5];
    r.is_tx = a[4];
    r.rsel  = reg_sel_e'(a[3:2]);
    r.bidx  = a[1:0];
    return r;
  endfunction

  function automatic logic [2:0] access_latency(input logic wr, input reg_sel_e s);
    if (wr) return 3'(WR_LAT);
    if (s == RG_CTRL || s == RG_STAT) return 3'(RD_FAST);
    return 3'(RD_SLOW);
  endfunction

  function automatic logic [1:0] lane_of(input logic [1:0] bidx, input int dw);
    case (dw)
      8:       return bidx;
      16:      return {1'b0, bidx[1]};
      default: return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/cpuif_seq.sv
module cpuif_seq
  import cpuif_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_n,
  input  logic          wen_n,
  input  logic [8:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output acc_t          acc_q,
  output logic          wr_q,
  output logic [DW-1:0] wdata_q
);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_HOLD} st_e;

  st_e        st;
  logic [2:0] cnt;
  logic [2:0] wlen;
  logic       req;
  logic       start;

  assign req   = !ren_n || !wen_n;
  assign start = (st == S_IDLE) && req;
  assign busy  = (st == S_BUSY);
  assign done  = (st == S_BUSY) && (cnt == 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      wlen    <= '0;
      acc_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          acc_q   <= decode_addr(addr);
          wr_q    <= ren_n;
          wdata_q <= wdata;
          cnt     <= access_latency(ren_n, reg_sel_e'(addr[3:2]));
          wlen    <= '0;
          st      <= S_BUSY;
        end
        S_BUSY: begin
          cnt  <= cnt - 3'd1;
          wlen <= wlen + 3'd1;
          if (cnt == 3'd1) st <= S_HOLD;
        end
        S_HOLD: if (!req) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  hold_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && req) |=> !busy);

  // R3
  fast_read_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_q && (acc_q.rsel == RG_CTRL || acc_q.rsel == RG_STAT)) |-> wlen == 3'd0);

  // R3
  slow_read_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_q && (acc_q.rsel == RG_DATA || acc_q.rsel == RG_LBL)) |-> wlen == 3'd5);

  // R4
  write_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wr_q) |-> wlen == 3'd1);

endmodule

// File: rtl/cpuif_stage.sv
module cpuif_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          part_wr,
  input  logic [1:0]    lane,
  input  logic [DW-1:0] din,
  output logic          commit,
  output logic [31:0]   word
);

  localparam int LANES = 32 / DW;
  localparam int LAST  = LANES - 1;

  assign commit = part_wr && (lane == 2'(LAST));

  generate
    if (LANES == 1) begin : g_direct
      assign word = din;
    end else begin : g_stage
      logic [DW-1:0] parts_q [LAST];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < LAST; k++) parts_q[k] <= '0;
        end else if (part_wr && !commit) begin
          parts_q[lane] <= din;
        end
      end

      always_comb begin
        word = '0;
        for (int g = 0; g < LAST; g++) word[g*DW +: DW] = parts_q[g];
        word[LAST*DW +: DW] = din;
      end
    end
  endgenerate

endmodule

// File: rtl/cpuif_chan.sv
module cpuif_chan
  import cpuif_pkg::*;
#(
  parameter bit HAS_LBL   = 1'b1,
  parameter int LBL_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        data_we,
  input  logic [31:0] data_wd,
  input  logic        ctrl_we,
  input  logic [7:0]  ctrl_wd,
  input  logic        lbl_we,
  input  logic        lbl_re,
  input  logic [7:0]  lbl_wd,
  input  reg_sel_e    rsel,
  output logic [31:0] rd_img,
  output logic        irq
);

  localparam int PW = (LBL_DEPTH > 1) ? $clog2(LBL_DEPTH) : 1;

  logic [31:0]   data_q;
  logic [7:0]    ctrl_q;
  logic [7:0]    stat_q;
  logic [7:0]    lbl_q;
  logic [7:0]    mem [LBL_DEPTH];
  logic [PW-1:0] wp, rp;
  logic          reload;

  assign stat_q = {7'b0, ~|data_q};
  assign irq    = |data_q;
  assign reload = ctrl_we && ctrl_wd[7];
  assign lbl_q  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (data_we) data_q <= data_wd;
      if (ctrl_we) ctrl_q <= ctrl_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < LBL_DEPTH; k++) mem[k] <= 8'h00;
      wp <= '0;
      rp <= '0;
    end else if (reload) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (lbl_we) begin
        mem[wp] <= lbl_wd;
        wp <= (wp == PW'(LBL_DEPTH-1)) ? '0 : wp + 1'b1;
      end
      if (lbl_re) rp <= (rp == PW'(LBL_DEPTH-1)) ? '0 : rp + 1'b1;
    end
  end

  always_comb begin
    case (rsel)
      RG_DATA: rd_img = data_q;
      RG_CTRL: rd_img = {24'b0, ctrl_q};
      RG_STAT: rd_img = {24'b0, stat_q};
      RG_LBL:  rd_img = HAS_LBL ? {24'b0, lbl_q} : 32'b0;
      default: rd_img = 32'b0;
    endcase
  end

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_we |=> $stable(data_q));

  // R9
  rd_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lbl_re && !ctrl_we) |=> $stable(rp));

  // R9
  wr_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lbl_we && !ctrl_we) |=> $stable(wp));

endmodule

// File: rtl/cpu_regif.sv
module cpu_regif
  import cpuif_pkg::*;
#(
  parameter int DW        = 8,
  parameter int NRX       = 2,
  parameter int NTX       = 2,
  parameter int LBL_DEPTH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_ren_n,
  input  logic           cpu_wen_n,
  input  logic [8:0]     cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  output logic           cpu_wait,
  output logic [NRX-1:0] rx_irq,
  output logic [NTX-1:0] tx_irq,
  output logic           irq_out
);

  acc_t          acc_q;
  logic          busy, done, wr_q;
  logic [DW-1:0] wd_q;
  logic [1:0]    lane;
  logic          present, lo_lane;
  logic          wr_done, rd_done, part_wr, commit;
  logic          ctrl_we_any, lbl_we_any, lbl_re_any;
  logic [31:0]   commit_word;
  logic [31:0]   rx_img [NRX];
  logic [31:0]   tx_img [NTX];
  logic [31:0]   rd_img;

  cpuif_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .ren_n(cpu_ren_n), .wen_n(cpu_wen_n),
    .addr(cpu_addr), .wdata(cpu_wdata), .busy(busy), .done(done),
    .acc_q(acc_q), .wr_q(wr_q), .wdata_q(wd_q)
  );

  assign cpu_wait = busy;
  assign lane     = lane_of(acc_q.bidx, DW);
  assign lo_lane  = (lane == 2'd0);
  assign present  = acc_q.is_tx ? (int'(acc_q.ch) < NTX) : (int'(acc_q.ch) < NRX);
  assign wr_done  = done && wr_q && present;
  assign rd_done  = done && !wr_q;
  assign part_wr  = wr_done && (acc_q.rsel == RG_DATA);

  assign ctrl_we_any = wr_done && (acc_q.rsel == RG_CTRL) && lo_lane;
  assign lbl_we_any  = wr_done && (acc_q.rsel == RG_LBL) && lo_lane && !acc_q.is_tx;
  assign lbl_re_any  = rd_done && present && (acc_q.rsel == RG_LBL) && lo_lane && !acc_q.is_tx;

  cpuif_stage #(.DW(DW)) u_stage (
    .clk(clk), .rst_n(rst_n), .part_wr(part_wr), .lane(lane),
    .din(wd_q), .commit(commit), .word(commit_word)
  );

  generate
    for (genvar i = 0; i < NRX; i++) begin : g_rx
      logic hit;
      assign hit = !acc_q.is_tx && (acc_q.ch == 4'(i));
      cpuif_chan #(.HAS_LBL(1'b1), .LBL_DEPTH(LBL_DEPTH)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .data_we(commit && hit), .data_wd(commit_word),
        .ctrl_we(ctrl_we_any && hit), .ctrl_wd(wd_q[7:0]),
        .lbl_we(lbl_we_any && hit), .lbl_re(lbl_re_any && hit), .lbl_wd(wd_q[7:0]),
        .rsel(acc_q.rsel), .rd_img(rx_img[i]), .irq(rx_irq[i])
      );
    end
    for (genvar j = 0; j < NTX; j++) begin : g_tx
      logic hit;
      assign hit = acc_q.is_tx && (acc_q.ch == 4'(j));
      cpuif_chan #(.HAS_LBL(1'b0), .LBL_DEPTH(LBL_DEPTH)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .data_we(commit && hit), .data_wd(commit_word),
        .ctrl_we(ctrl_we_any && hit), .ctrl_wd(wd_q[7:0]),
        .lbl_we(1'b0), .lbl_re(1'b0), .lbl_wd(8'h00),
        .rsel(acc_q.rsel), .rd_img(tx_img[j]), .irq(tx_irq[j])
      );
    end
  endgenerate

  always_comb begin
    rd_img = 32'b0;
    for (int i = 0; i < NRX; i++)
      if (!acc_q.is_tx && acc_q.ch == 4'(i)) rd_img = rx_img[i];
    for (int j = 0; j < NTX; j++)
      if (acc_q.is_tx && acc_q.ch == 4'(j)) rd_img = tx_img[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_rdata <= '0;
    else if (rd_done) cpu_rdata <= DW'(rd_img >> (int'(lane) * DW));
  end

  assign irq_out = |{rx_irq, tx_irq};

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> $stable(cpu_rdata));

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(commit));

  // R10
  absent_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wr_q && !present) |=> ($stable(rx_irq) && $stable(tx_irq)));

endmodule

// File: tb/cpu_regif_bench.sv
`timescale 1ns/1ps
module cpu_regif_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_ren_n = 1'b1;
  logic       cpu_wen_n = 1'b1;
  logic [8:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       cpu_wait;
  logic [1:0] rx_irq;
  logic [1:0] tx_irq;
  logic       irq_out;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  cpu_regif #(.DW(8), .NRX(2), .NTX(2), .LBL_DEPTH(4)) u_cpu_regif (
    .clk(clk), .rst_n(rst_n), .cpu_ren_n(cpu_ren_n), .cpu_wen_n(cpu_wen_n),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_wait(cpu_wait), .rx_irq(rx_irq), .tx_irq(tx_irq), .irq_out(irq_out)
  );

  function automatic logic [8:0] ad(input int ch, input int tx, input int rg, input int b);
    return {4'(ch), 1'(tx), 2'(rg), 2'(b)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [8:0] a, input logic [7:0] wd,
                        output logic [7:0] rd, output int n);
    @(negedge clk);
    cpu_addr  = a;
    cpu_wdata = wd;
    if (wr) cpu_wen_n = 1'b0; else cpu_ren_n = 1'b0;
    n = 0;
    @(negedge clk);
    while (cpu_wait && n < 20) begin
      n++;
      @(negedge clk);
    end
    rd = cpu_rdata;
    cpu_ren_n = 1'b1;
    cpu_wen_n = 1'b1;
  endtask

  task automatic wr(input string tag, input logic [8:0] a, input logic [7:0] wd);
    logic [7:0] rd;
    int n;
    access(1'b1, a, wd, rd, n);
    chk({tag, " R4 write wait"}, n, 2);
  endtask

  task automatic rd_chk(input string tag, input logic [8:0] a, input logic [7:0] exp, input int lat);
    logic [7:0] rd;
    int n;
    access(1'b0, a, 8'h00, rd, n);
    chk({tag, " R3 read wait"}, n, lat);
    chk(tag, rd, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int n;
    repeat (3) @(negedge clk);
    chk("R12 wait after reset", cpu_wait, 0);
    chk("R12 rdata after reset", cpu_rdata, 0);
    chk("R12 irq after reset", irq_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R12 rx0 data zero", ad(0, 0, 0, 0), 8'h00, 6);
    rd_chk("R12 R8 rx1 status empty", ad(1, 0, 2, 0), 8'h01, 1);

    // R1 sweep over every channel and direction
    for (int tx = 0; tx < 2; tx++)
      for (int ch = 0; ch < 16; ch++)
        wr("R1", ad(ch, tx, 1, 0), 8'(ch * 16 + tx * 8 + 5));
    for (int tx = 0; tx < 2; tx++)
      for (int ch = 0; ch < 16; ch++)
        rd_chk((ch < 2) ? "R1 ctrl readback" : "R10 absent ctrl",
               ad(ch, tx, 1, 0), (ch < 2) ? 8'(ch * 16 + tx * 8 + 5) : 8'h00, 1);

    // R7 upper lanes of control
    rd_chk("R7 ctrl lane2 zero", ad(1, 0, 1, 2), 8'h00, 1);
    wr("R7", ad(1, 0, 1, 1), 8'h5A);
    rd_chk("R7 ctrl lane0 kept", ad(1, 0, 1, 0), 8'h15, 1);

    // R6 R5 staged data word on rx0
    wr("R6", ad(0, 0, 0, 0), 8'h44);
    wr("R6", ad(0, 0, 0, 1), 8'h33);
    wr("R6", ad(0, 0, 0, 2), 8'h22);
    rd_chk("R6 word not committed", ad(0, 0, 0, 0), 8'h00, 6);
    chk("R6 irq before commit", irq_out, 0);
    wr("R6", ad(0, 0, 0, 3), 8'h11);
    chk("R11 rx_irq at commit", rx_irq, 2'b01);
    chk("R11 irq_out at commit", irq_out, 1);
    for (int b = 0; b < 4; b++)
      rd_chk("R5 lane readback", ad(0, 0, 0, b), 8'(8'h44 - 8'(b) * 8'h11), 6);
    rd_chk("R8 status not empty", ad(0, 0, 2, 0), 8'h00, 1);
    wr("R8", ad(0, 0, 2, 0), 8'hFF);
    rd_chk("R8 status write ignored", ad(0, 0, 2, 0), 8'h00, 1);

    // R6 staged parts shared across channels; final write picks target
    wr("R6", ad(1, 1, 0, 0), 8'hAA);
    wr("R6", ad(0, 1, 0, 1), 8'hBB);
    wr("R6", ad(0, 1, 0, 2), 8'hCC);
    wr("R6", ad(0, 1, 0, 3), 8'hDD);
    chk("R11 tx_irq", tx_irq, 2'b01);
    rd_chk("R6 shared stage byte0", ad(0, 1, 0, 0), 8'hAA, 6);
    rd_chk("R6 shared stage byte3", ad(0, 1, 0, 3), 8'hDD, 6);
    rd_chk("R6 tx1 untouched", ad(1, 1, 0, 0), 8'h00, 6);

    // R11 clearing words
    for (int b = 0; b < 4; b++) wr("R11", ad(0, 0, 0, b), 8'h00);
    chk("R11 rx cleared", rx_irq, 2'b00);
    chk("R11 irq_out still tx", irq_out, 1);
    for (int b = 0; b < 4; b++) wr("R11", ad(0, 1, 0, b), 8'h00);
    chk("R11 irq_out cleared", irq_out, 0);

    // R10 absent channels and unused slot
    for (int b = 0; b < 4; b++) wr("R10", ad(7, 0, 0, b), 8'h5C);
    chk("R10 absent write no irq", irq_out, 0);
    rd_chk("R10 absent data", ad(7, 0, 0, 0), 8'h00, 6);
    wr("R10", ad(0, 1, 3, 0), 8'h77);
    rd_chk("R10 tx label slot", ad(0, 1, 3, 0), 8'h00, 6);
    rd_chk("R10 absent label", ad(9, 0, 3, 0), 8'h00, 6);

    // R9 label store on rx0
    wr("R9", ad(0, 0, 1, 0), 8'h80);
    rd_chk("R9 ctrl bit7 readback", ad(0, 0, 1, 0), 8'h80, 1);
    for (int k = 0; k < 4; k++) wr("R9", ad(0, 0, 3, 0), 8'(8'hA0 + k));
    for (int k = 0; k < 4; k++) rd_chk("R9 label read", ad(0, 0, 3, 0), 8'(8'hA0 + k), 6);
    rd_chk("R9 read wrap", ad(0, 0, 3, 0), 8'hA0, 6);
    wr("R9", ad(0, 0, 3, 0), 8'hB0);
    rd_chk("R9 pointers independent", ad(0, 0, 3, 0), 8'hA1, 6);
    wr("R9", ad(0, 0, 1, 0), 8'h80);
    wr("R9", ad(0, 0, 3, 0), 8'hC5);
    rd_chk("R9 after reload", ad(0, 0, 3, 0), 8'hC5, 6);
    rd_chk("R9 label lane1 zero", ad(0, 0, 3, 1), 8'h00, 6);
    rd_chk("R9 lane1 no advance", ad(0, 0, 3, 0), 8'hA1, 6);

    // R2 enable held past completion gives one access only
    wr("R2", ad(1, 0, 1, 0), 8'h80);
    wr("R2", ad(1, 0, 3, 0), 8'h11);
    wr("R2", ad(1, 0, 3, 0), 8'h22);
    @(negedge clk);
    cpu_addr  = ad(1, 0, 3, 0);
    cpu_ren_n = 1'b0;
    n = 0;
    @(negedge clk);
    chk("R2 wait rises", cpu_wait, 1);
    while (cpu_wait && n < 20) begin
      n++;
      @(negedge clk);
    end
    chk("R2 first label", cpu_rdata, 8'h11);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 no restart while held", cpu_wait, 0);
    end
    cpu_ren_n = 1'b1;
    rd_chk("R2 single advance", ad(1, 0, 3, 0), 8'h22, 6);

    // R2 both enables low reads
    @(negedge clk);
    cpu_addr  = ad(1, 0, 1, 0);
    cpu_wdata = 8'h3C;
    cpu_ren_n = 1'b0;
    cpu_wen_n = 1'b0;
    access(1'b0, ad(1, 0, 1, 0), 8'h3C, rd, n);
    chk("R2 both low is read", rd, 8'h80);
    rd_chk("R2 ctrl not written", ad(1, 0, 1, 0), 8'h80, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule